// File: doc/BRIEF.md
# Time-Multiplexed Core Input Scheduler

This block sits between a tower-data input stage and a small pool of processing cores that run five times faster than the crossing rate. A narrow load pulse captures one crossing's worth of tower data: 60 towers, laid out as 6 eta columns of 10 rows. The 40 towers in the four inner columns are core jobs. Each of them needs one result. The two outer columns act only as environment. Over the five fast cycles that follow the capture, the block hands 8 jobs per cycle to 8 cores, which covers all 40 jobs in one crossing. Each job arrives with its eta neighbours.

When the region lies on a detector border, a configuration input forces the missing outer column to zero before any core sees it. Each core bus carries a slot index, a start marker on slot 0 and a valid flag, so downstream logic can frame the results by crossing. A load pulse that arrives early makes the counter re-align to slot 0 and sets a sticky misalignment flag.

Top module: `tower_core_scheduler`

## Requirements
- R1: After a synchronous active-low reset, valid_o, start_o, misalign_o, slot_o and every bit of core_towers_o are 0, and they stay so until the first load.
- R2: On a clock edge where load_i is 1, all of towers_i is captured. Tower t = col*10 + row occupies bits [t*8 +: 8]. Values on towers_i while load_i is 0 have no effect on any output.
- R3: The output stage lags the capture edge by one cycle. After the first edge following a capture, slot_o is 0, and it then advances by 1 each cycle up to 4.
- R4: In slot s, core k works on job j = s*8 + k, which lies in row j%10 and column 1 + j/10. Lane p of core k sits at core_towers_o[(k*3+p)*8 +: 8] and holds the tower in column j/10 + p of that row. Lane 0 is the left neighbour, lane 1 the job tower and lane 2 the right neighbour.
- R5: start_o is 1 exactly when valid_o is 1 and slot_o is 0.
- R6: If left_border_i is 1 at the capture edge, every lane that would show a column-0 tower (towers 0..9) shows zero for that crossing.
- R7: If right_border_i is 1 at the capture edge, every lane that would show a column-5 tower (towers 50..59) shows zero for that crossing.
- R8: With both border inputs 1, both outer columns read as zero. The inner columns are unchanged.
- R9: Loads spaced exactly 5 cycles apart produce gap-free back-to-back crossings and leave misalign_o at 0.
- R10: A load that arrives while the running slot is not 4 restarts the output framing at slot 0 with the new data and sets misalign_o. The flag stays 1 until reset.
- R11: If no load arrives after slot 4, the counter wraps to slot 0 and the held crossing data is presented again.
- R12: valid_o rises on the cycle after the first capture and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | One-cycle pulse marking the first fast cycle of a crossing |
| towers_i | input | 480 | Parallel tower data, 60 towers of 8 bits |
| left_border_i | input | 1 | Force column 0 to zero at capture |
| right_border_i | input | 1 | Force column 5 to zero at capture |
| core_towers_o | output | 192 | Per-core left/job/right tower lanes, 8 cores x 3 lanes x 8 bits |
| slot_o | output | 3 | Slot index of the presented jobs |
| start_o | output | 1 | High with slot 0 of each framed crossing |
| valid_o | output | 1 | Outputs carry captured data |
| misalign_o | output | 1 | Sticky flag for an early load |

## Verification
The bench streams crossings whose tower values are a distinct function of the tower index and a per-crossing seed. A lane that picks the wrong row, column, slot or crossing therefore shows a value that differs from the expected one. Streams run with no border, left border, right border and both borders. This separates the zeroing of each outer column from the plain job mapping. Between loads, towers_i carries unrelated values, which shows that data is taken only at the load edge. A missing load exercises the wrap-around repeat, and an early load exercises resynchronisation and the sticky flag. Both can be told apart from aligned back-to-back streams, which must leave the flag clear.

// File: rtl/tcs_pkg.sv
// Package: shared constants and index helpers for the core input scheduler.
// Assumes towers are numbered column-major: tower = col * rows + row.
package tcs_pkg;

    // Lanes handed to a core with each job: left neighbour, job tower, right neighbour.
    typedef enum logic [1:0] {
        LANE_LEFT   = 2'd0,
        LANE_CENTRE = 2'd1,
        LANE_RIGHT  = 2'd2
    } lane_e;

    localparam int LANES = 3;

    // Tower feeding lane p of job j; job j sits in row j%rows, column 1 + j/rows.
    function automatic int lane_tower(input int job, input int lane, input int rows);
        int col;
        int row;
        col = (job / rows) + lane;
        row = job % rows;
        return col * rows + row;
    endfunction

endpackage

// File: rtl/tcs_slot_ctrl.sv
// Module: slot sequencer. It counts the fast cycles of a crossing, restarts
// at slot 0 on every load and flags a load that arrives before the last slot.
// Assumes load_i is one cycle wide and synchronous to clk.
module tcs_slot_ctrl #(
    parameter int N_SLOTS = 5,
    parameter int SLOT_W  = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              running_o,
    output logic              misalign_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;
    logic              running_q;
    logic              misalign_q;

    // Slot counter, run state and sticky early-load flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q     <= '0;
            running_q  <= 1'b0;
            misalign_q <= 1'b0;
        end else if (load_i) begin
            slot_q    <= '0;
            running_q <= 1'b1;
            if (running_q && (slot_q != LAST_SLOT))
                misalign_q <= 1'b1;
        end else if (running_q) begin
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        end
    end

    assign slot_o     = slot_q;
    assign running_o  = running_q;
    assign misalign_o = misalign_q;

    assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LAST_SLOT);

    assert_slot_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !load_i && slot_q != LAST_SLOT) |=> (slot_q == $past(slot_q) + 1'b1));

    assert_slot_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !load_i && slot_q == LAST_SLOT) |=> (slot_q == '0));

    assert_load_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (slot_q == '0 && running_q));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_q |=> misalign_q);

    assert_aligned_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && slot_q == LAST_SLOT && !misalign_q) |=> !misalign_q);

endmodule

// File: rtl/tcs_tower_bank.sv
// Module: crossing tower store. It captures the whole tower bus on load and
// zeroes an outer column when the matching border input is set.
// Assumes the border inputs are stable around the load edge.
module tcs_tower_bank #(
    parameter int TOWER_W   = 8,
    parameter int ROWS      = 10,
    parameter int CORE_COLS = 4,
    parameter int N_COLS    = CORE_COLS + 2,
    parameter int N_TOWERS  = N_COLS * ROWS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic                        left_i,
    input  logic                        right_i,
    input  logic [N_TOWERS*TOWER_W-1:0] towers_i,
    output logic [N_TOWERS*TOWER_W-1:0] bank_o
);
    for (genvar t = 0; t < N_TOWERS; t++) begin : g_tower
        localparam int  COL     = t / ROWS;
        localparam bit  IS_LEFT  = (COL == 0);
        localparam bit  IS_RIGHT = (COL == N_COLS - 1);

        logic [TOWER_W-1:0] cell_q;
        logic               zap;

        // Border zeroing for this tower's column.
        always_comb zap = (IS_LEFT && left_i) || (IS_RIGHT && right_i);

        // Capture one tower on load.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (load_i)
                cell_q <= zap ? '0 : towers_i[t*TOWER_W +: TOWER_W];
        end

        assign bank_o[t*TOWER_W +: TOWER_W] = cell_q;
    end

    assert_left_col_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && left_i) |=> (bank_o[ROWS*TOWER_W-1:0] == '0));

    assert_right_col_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && right_i) |=> (bank_o[N_TOWERS*TOWER_W-1 -: ROWS*TOWER_W] == '0));

    assert_hold_without_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(bank_o));

endmodule

// File: rtl/tcs_core_mux.sv
// Module: per-core job selector. For the current slot it routes each core's
// job tower and its two eta neighbours out of the tower store.
// Assumes N_CORES * N_SLOTS equals the number of core towers.
module tcs_core_mux
    import tcs_pkg::*;
#(
    parameter int TOWER_W  = 8,
    parameter int ROWS     = 10,
    parameter int N_CORES  = 8,
    parameter int N_SLOTS  = 5,
    parameter int N_TOWERS = 60,
    parameter int SLOT_W   = $clog2(N_SLOTS)
) (
    input  logic [N_TOWERS*TOWER_W-1:0]      bank_i,
    input  logic [SLOT_W-1:0]                slot_i,
    output logic [N_CORES*LANES*TOWER_W-1:0] lanes_o
);
    localparam int CORE_BITS = LANES * TOWER_W;

    for (genvar k = 0; k < N_CORES; k++) begin : g_core
        logic [CORE_BITS-1:0] sel;

        // Pick core k's three lanes for the active slot.
        always_comb begin
            sel = '0;
            for (int s = 0; s < N_SLOTS; s++) begin
                if (slot_i == SLOT_W'(s)) begin
                    for (int p = 0; p < LANES; p++) begin
                        sel[p*TOWER_W +: TOWER_W] =
                            bank_i[lane_tower(s*N_CORES + k, p, ROWS)*TOWER_W +: TOWER_W];
                    end
                end
            end
        end

        assign lanes_o[k*CORE_BITS +: CORE_BITS] = sel;
    end

endmodule

// File: rtl/tower_core_scheduler.sv
// Module: top of the core input scheduler. It captures a crossing on load,
// steps through its slots and registers the per-core lanes with slot, start,
// valid and misalignment markers. Outputs lag the slot counter by one cycle.
// Assumes one load per crossing, every N_SLOTS fast cycles.
module tower_core_scheduler
    import tcs_pkg::*;
#(
    parameter int TOWER_W   = 8,
    parameter int ROWS      = 10,
    parameter int CORE_COLS = 4,
    parameter int N_CORES   = 8,
    parameter int N_SLOTS   = 5,
    localparam int N_COLS   = CORE_COLS + 2,
    localparam int N_TOWERS = N_COLS * ROWS,
    localparam int SLOT_W   = $clog2(N_SLOTS),
    localparam int OUT_W    = N_CORES * LANES * TOWER_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [N_TOWERS*TOWER_W-1:0] towers_i,
    input  logic                        left_border_i,
    input  logic                        right_border_i,
    output logic [OUT_W-1:0]            core_towers_o,
    output logic [SLOT_W-1:0]           slot_o,
    output logic                        start_o,
    output logic                        valid_o,
    output logic                        misalign_o
);
    logic [SLOT_W-1:0]           slot;
    logic                        running;
    logic [N_TOWERS*TOWER_W-1:0] bank;
    logic [OUT_W-1:0]            lanes;

    logic [OUT_W-1:0]  out_q;
    logic [SLOT_W-1:0] slot_q;
    logic              start_q;
    logic              valid_q;

    tcs_slot_ctrl #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) slot_ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .slot_o     (slot),
        .running_o  (running),
        .misalign_o (misalign_o)
    );

    tcs_tower_bank #(
        .TOWER_W(TOWER_W), .ROWS(ROWS), .CORE_COLS(CORE_COLS),
        .N_COLS(N_COLS), .N_TOWERS(N_TOWERS)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .left_i   (left_border_i),
        .right_i  (right_border_i),
        .towers_i (towers_i),
        .bank_o   (bank)
    );

    tcs_core_mux #(
        .TOWER_W(TOWER_W), .ROWS(ROWS), .N_CORES(N_CORES),
        .N_SLOTS(N_SLOTS), .N_TOWERS(N_TOWERS), .SLOT_W(SLOT_W)
    ) mux_i (
        .bank_i  (bank),
        .slot_i  (slot),
        .lanes_o (lanes)
    );

    // Output stage: register lanes and framing markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            slot_q  <= '0;
            start_q <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            out_q   <= running ? lanes : '0;
            slot_q  <= slot;
            start_q <= running && (slot == '0);
            valid_q <= running;
        end
    end

    assign core_towers_o = out_q;
    assign slot_o        = slot_q;
    assign start_o       = start_q;
    assign valid_o       = valid_q;

    assert_start_on_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (valid_o && slot_o == '0));

    assert_valid_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (core_towers_o == '0 && !start_o));

    assert_capture_to_slot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_i) |=> (slot_o == '0 && start_o));

endmodule

// File: tb/tower_core_scheduler_tb.sv
// Bench: directed scenarios for the core input scheduler, one task each.
module tower_core_scheduler_tb_top;
    localparam int W      = 8;
    localparam int ROWS   = 10;
    localparam int NCOL   = 6;
    localparam int NT     = NCOL * ROWS;
    localparam int NC     = 8;
    localparam int NS     = 5;
    localparam int OUT_W  = NC * 3 * W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load = 1'b0;
    logic [NT*W-1:0]   towers = '0;
    logic              lb = 1'b0;
    logic              rb = 1'b0;
    logic [OUT_W-1:0]  core_towers;
    logic [2:0]        slot;
    logic              start;
    logic              valid;
    logic              misalign;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    tower_core_scheduler dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_i         (load),
        .towers_i       (towers),
        .left_border_i  (lb),
        .right_border_i (rb),
        .core_towers_o  (core_towers),
        .slot_o         (slot),
        .start_o        (start),
        .valid_o        (valid),
        .misalign_o     (misalign)
    );

    function automatic logic [W-1:0] tval(input int seed, input int t);
        return W'(t * 7 + seed * 13 + 5);
    endfunction

    function automatic logic [NT*W-1:0] din(input int seed);
        logic [NT*W-1:0] v;
        for (int t = 0; t < NT; t++) v[t*W +: W] = tval(seed, t);
        return v;
    endfunction

    // Expected lanes from R4 mapping with R6/R7 zeroing.
    function automatic logic [OUT_W-1:0] exp_bus(input int seed, input bit l, input bit r, input int s);
        logic [OUT_W-1:0] v;
        for (int k = 0; k < NC; k++) begin
            for (int p = 0; p < 3; p++) begin
                int j;
                int col;
                int row;
                j   = s * NC + k;
                row = j % ROWS;
                col = j / ROWS + p;
                if ((col == 0 && l) || (col == NCOL - 1 && r))
                    v[(k*3+p)*W +: W] = '0;
                else
                    v[(k*3+p)*W +: W] = tval(seed, col * ROWS + row);
            end
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        load  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: quiet outputs after reset.
    task automatic t_reset();
        do_reset();
        @(posedge clk); #1;
        chk(valid == 1'b0, "R1 valid", OUT_W'(valid), 0);
        chk(start == 1'b0, "R1 start", OUT_W'(start), 0);
        chk(misalign == 1'b0, "R1 misalign", OUT_W'(misalign), 0);
        chk(slot == 3'd0, "R1 slot", OUT_W'(slot), 0);
        chk(core_towers == '0, "R1 lanes", core_towers, '0);
    endtask

    // R2..R9, R12: n back-to-back crossings, garbage between loads.
    task automatic t_stream(input int n, input int seed0, input bit l, input bit r, input bit rst);
        if (rst) do_reset();
        @(negedge clk);
        lb = l; rb = r;
        towers = din(seed0);
        load = 1'b1;
        for (int cyc = 0; cyc <= 5 * n; cyc++) begin
            @(posedge clk); #1;
            if (cyc >= 1) begin
                int x;
                int s;
                x = (cyc - 1) / NS;
                s = (cyc - 1) % NS;
                chk(core_towers == exp_bus(seed0 + x, l, r, s),
                    l && r ? "R8 lanes" : l ? "R6 lanes" : r ? "R7 lanes" : "R4 lanes",
                    core_towers, exp_bus(seed0 + x, l, r, s));
                chk(slot == 3'(s), "R3 slot", OUT_W'(slot), OUT_W'(s));
                chk(start == (s == 0), "R5 start", OUT_W'(start), OUT_W'(s == 0));
                chk(valid == 1'b1, "R12 valid", OUT_W'(valid), 1);
                chk(misalign == 1'b0, "R9 misalign", OUT_W'(misalign), 0);
            end
            @(negedge clk);
            if (cyc % NS == 4 && (cyc / NS) + 1 < n) begin
                load   = 1'b1;
                towers = din(seed0 + cyc / NS + 1);
            end else begin
                load   = 1'b0;
                towers = din(seed0 + 77 + cyc);   // R2: ignored while load low
            end
        end
    endtask

    // R11 wrap repeat, then R10 early load and sticky flag.
    task automatic t_misalign();
        t_stream(1, 20, 1'b0, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk(slot == 3'd0 && start, "R11 wrap slot", OUT_W'(slot), 0);
        chk(core_towers == exp_bus(20, 0, 0, 0), "R11 repeat", core_towers, exp_bus(20, 0, 0, 0));
        @(posedge clk); #1;
        chk(slot == 3'd1, "R11 slot1", OUT_W'(slot), 1);
        @(negedge clk);
        load = 1'b1;
        towers = din(40);
        @(posedge clk); #1;
        chk(misalign == 1'b1, "R10 flag set", OUT_W'(misalign), 1);
        @(negedge clk);
        load = 1'b0;
        towers = din(3);
        @(posedge clk); #1;
        chk(slot == 3'd0 && start, "R10 resync slot", OUT_W'(slot), 0);
        chk(core_towers == exp_bus(40, 0, 0, 0), "R10 new data", core_towers, exp_bus(40, 0, 0, 0));
        repeat (7) @(posedge clk);
        #1;
        chk(misalign == 1'b1, "R10 sticky", OUT_W'(misalign), 1);
        do_reset();
        @(posedge clk); #1;
        chk(misalign == 1'b0 && valid == 1'b0, "R1 reset clears flag", OUT_W'(misalign), 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_stream(3, 1, 1'b0, 1'b0, 1'b1);
        t_stream(2, 5, 1'b1, 1'b0, 1'b1);
        t_stream(2, 9, 1'b0, 1'b1, 1'b1);
        t_stream(2, 14, 1'b1, 1'b1, 1'b1);
        t_misalign();
        t_reset();
        finish_run();
    end

endmodule